// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address under a 4-bit context into a 36-bit physical address by reading translation tables that live in ordinary memory. A walk starts at a context table whose base comes from a pointer input. It then descends through a region table, a segment table and a page table, one word-wide read per level, over a simple request/acknowledge memory port.

Each fetched word carries a 2-bit type. It is either a pointer to the next table or a terminal page entry, and a terminal entry may appear above the last level to map a large page. The entry's 3-bit permission code is checked against the access kind (read, write or instruction fetch) and the privilege (user or supervisor). The walker then marks the entry referenced, and modified on a data write, by writing it back. The result is a single-cycle done pulse with the physical address and a cacheable flag, or a single-cycle fault pulse with a code and the level where the walk stopped. Only one walk runs at a time.

Top module: `tbl_walker`

## Requirements
- R1: A table word whose bits 1:0 are 0 (invalid) ends the walk with fault code 1. A word with bits 1:0 equal to 3 (reserved) ends it with fault code 2. Either fault reports the level being read: 0 context, 1 region, 2 segment, 3 page.
- R2: The first read of a walk goes to byte address {ctx_table_base, req_ctx, 2'b00}.
- R3: A word with bits 1:0 equal to 1 is a pointer. The next read goes to ({word[31:2], 6'b0}) + 4*index, where the index is vaddr[31:24] for the region table, vaddr[23:18] for the segment table and vaddr[17:12] for the page table. A walk that ends at level L makes exactly L+1 reads.
- R4: A pointer word found at level 3 ends the walk with fault code 3, level 3.
- R5: A word with bits 1:0 equal to 2 is an entry whose permission code is bits 4:2. The codes, written as user/supervisor rights, are: 0 R/R, 1 RW/RW, 2 RX/RX, 3 RWX/RWX, 4 X/X, 5 R/RW, 6 none/RX, 7 none/RWX. When req_exec is set the access is checked as a fetch, otherwise it is checked as a write when req_write is set and as a read when it is clear. A denied access gives fault code 4 at the entry's level, and no write is made.
- R6: On success the new entry value is the fetched word with bit 5 (referenced) set, and also bit 6 (modified) when req_write is set and req_exec is clear. Exactly one write of that value goes to the entry's own address, and only if the value differs from the fetched word.
- R7: For an entry at level 3, phys_addr = {word[31:8], vaddr[11:0]}, and phys_cacheable equals word bit 7.
- R8: An entry at level 2 gives {word[31:14], vaddr[17:0]}. An entry at level 1 gives {word[31:20], vaddr[23:0]}. An entry at level 0 gives {word[31:28], vaddr[31:0]}.
- R9: walk_done and walk_fault are single-cycle pulses that never occur together. req_ready is low from the accepting cycle through the pulse cycle, and it returns high in the cycle after the pulse.
- R10: During and just after reset, req_ready is high and mem_req, walk_done and walk_fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctx | input | 4 | Context number |
| req_write | input | 1 | Data write access |
| req_exec | input | 1 | Instruction fetch access |
| req_user | input | 1 | User privilege (0 = supervisor) |
| ctx_table_base | input | 30 | Context table base, byte address bits 35:6 |
| mem_req | output | 1 | Memory request strobe, one cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 36 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed, read data valid |
| mem_rdata | input | 32 | Read data |
| walk_done | output | 1 | Translation succeeded (pulse) |
| walk_fault | output | 1 | Translation failed (pulse) |
| fault_code | output | 3 | 1 invalid, 2 reserved, 3 pointer at page level, 4 permission |
| fault_level | output | 2 | Level where the walk stopped |
| phys_addr | output | 36 | Physical byte address |
| phys_cacheable | output | 1 | Entry cacheable bit |

## Verification
The bench goes after large pages at every upper level. A walker that always splices the offset at bit 12 would return wrong high address bits for these. It checks that a pointer at the page level faults instead of being followed into garbage, and it covers the asymmetric permission codes (user write on code 5, supervisor write on code 0, user access on code 6, user fetch on code 4), where a swapped user/supervisor column would let the access through. It also covers an entry whose referenced bit is already set, so the walker must skip the write-back. And it covers a fetch with the write flag also raised, which must not set the modified bit.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 36;
  localparam int WORD_W = 32;
  localparam int CTX_W  = 4;
  localparam int LVL_W  = 2;
  localparam int IDX_W  = 8;
  localparam int PPN_LO = 8;
  localparam int B_CACHE = 7;
  localparam int B_MOD   = 6;
  localparam int B_REF   = 5;
  localparam int PERM_LO = 2;
  localparam int LAST_LVL = 3;

  typedef enum logic [1:0] {TE_INVALID = 2'd0, TE_POINTER = 2'd1,
                            TE_ENTRY = 2'd2, TE_RESERVED = 2'd3} tentry_e;
  typedef enum logic [2:0] {FC_NONE = 3'd0, FC_INVALID = 3'd1, FC_RESERVED = 3'd2,
                            FC_DEEP_PTR = 3'd3, FC_PROT = 3'd4} fault_e;
  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_RDW, ST_WR, ST_WRW} walk_st_e;
endpackage

// File: rtl/ptw_perm.sv
module ptw_perm (
  input  logic [2:0] code,
  input  logic       user,
  input  logic       wr,
  input  logic       ex,
  output logic       allow
);
  logic rd_ok, wr_ok, ex_ok;
  always_comb begin
    if (user) begin
      rd_ok = code inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5};
      wr_ok = code inside {3'd1, 3'd3};
      ex_ok = code inside {3'd2, 3'd3, 3'd4};
    end else begin
      rd_ok = (code != 3'd4);
      wr_ok = code inside {3'd1, 3'd3, 3'd5, 3'd7};
      ex_ok = code inside {3'd2, 3'd3, 3'd4, 3'd6, 3'd7};
    end
    allow = ex ? ex_ok : (wr ? wr_ok : rd_ok);
  end
endmodule

// File: rtl/ptw_pa.sv
module ptw_pa
  import ptw_pkg::*;
(
  input  logic [WORD_W-PPN_LO-1:0] ppn,
  input  logic [VA_W-1:0]          va,
  input  logic [LVL_W-1:0]         lvl,
  output logic [PA_W-1:0]          pa
);
  always_comb begin
    case (lvl)
      2'd0:    pa = {ppn[23:20], va};
      2'd1:    pa = {ppn[23:12], va[23:0]};
      2'd2:    pa = {ppn[23:6],  va[17:0]};
      default: pa = {ppn,        va[11:0]};
    endcase
  end
endmodule

// File: rtl/ptw_next.sv
module ptw_next
  import ptw_pkg::*;
(
  input  logic [WORD_W-3:0]  desc_hi,
  input  logic [VA_W-1:0]    va,
  input  logic [LVL_W-1:0]   lvl_next,
  output logic [PA_W-1:0]    addr
);
  localparam int BASE_PAD = PA_W - (WORD_W - 2);
  localparam int IDX_PAD  = PA_W - IDX_W - 2;
  logic [IDX_W-1:0] idx;
  always_comb begin
    case (lvl_next)
      2'd1:    idx = va[31:24];
      2'd2:    idx = {2'b00, va[23:18]};
      default: idx = {2'b00, va[17:12]};
    endcase
    addr = {desc_hi, {BASE_PAD{1'b0}}} + {{IDX_PAD{1'b0}}, idx, 2'b00};
  end
endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic              req_write,
  input  logic              req_exec,
  input  logic              req_user,
  input  logic [PA_W-1:6]   ctx_table_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              walk_done,
  output logic              walk_fault,
  output logic [2:0]        fault_code,
  output logic [LVL_W-1:0]  fault_level,
  output logic [PA_W-1:0]   phys_addr,
  output logic              phys_cacheable
);
  walk_st_e          state;
  logic [LVL_W-1:0]  lvl;
  logic [VA_W-1:0]   va_q;
  logic              user_q, wr_q, ex_q;
  logic [PA_W-1:0]   cur_addr;
  logic [WORD_W-1:0] pte_new;

  tentry_e           rtype;
  logic [LVL_W-1:0]  lvl_nx;
  logic [PA_W-1:0]   nxt_addr;
  logic [PA_W-1:0]   pa_w;
  logic              allow;
  logic [WORD_W-1:0] upd;

  assign rtype  = tentry_e'(mem_rdata[1:0]);
  assign lvl_nx = lvl + 2'd1;
  assign upd    = mem_rdata | (WORD_W'(1) << B_REF)
                | ((wr_q && !ex_q) ? (WORD_W'(1) << B_MOD) : '0);

  ptw_next u_next (.desc_hi(mem_rdata[WORD_W-1:2]), .va(va_q), .lvl_next(lvl_nx), .addr(nxt_addr));
  ptw_pa   u_pa   (.ppn(mem_rdata[WORD_W-1:PPN_LO]), .va(va_q), .lvl(lvl), .pa(pa_w));
  ptw_perm u_perm (.code(mem_rdata[PERM_LO+2:PERM_LO]), .user(user_q), .wr(wr_q),
                   .ex(ex_q), .allow(allow));

  assign req_ready = (state == ST_IDLE) && !walk_done && !walk_fault;
  assign mem_req   = (state == ST_RD) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = cur_addr;
  assign mem_wdata = pte_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; lvl <= '0; va_q <= '0; user_q <= 1'b0; wr_q <= 1'b0; ex_q <= 1'b0;
      cur_addr <= '0; pte_new <= '0; walk_done <= 1'b0; walk_fault <= 1'b0;
      fault_code <= FC_NONE; fault_level <= '0; phys_addr <= '0; phys_cacheable <= 1'b0;
    end else begin
      walk_done  <= 1'b0;
      walk_fault <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid && req_ready) begin
          va_q <= req_vaddr; user_q <= req_user; wr_q <= req_write; ex_q <= req_exec;
          cur_addr <= {ctx_table_base, req_ctx, 2'b00};
          lvl <= '0;
          state <= ST_RD;
        end
        ST_RD: state <= ST_RDW;
        ST_RDW: if (mem_ack) begin
          case (rtype)
            TE_POINTER: if (lvl == LVL_W'(LAST_LVL)) begin
              walk_fault <= 1'b1; fault_code <= FC_DEEP_PTR; fault_level <= lvl; state <= ST_IDLE;
            end else begin
              cur_addr <= nxt_addr; lvl <= lvl_nx; state <= ST_RD;
            end
            TE_ENTRY: if (!allow) begin
              walk_fault <= 1'b1; fault_code <= FC_PROT; fault_level <= lvl; state <= ST_IDLE;
            end else begin
              phys_addr <= pa_w; phys_cacheable <= mem_rdata[B_CACHE]; pte_new <= upd;
              if (upd != mem_rdata) state <= ST_WR;
              else begin walk_done <= 1'b1; state <= ST_IDLE; end
            end
            TE_INVALID: begin
              walk_fault <= 1'b1; fault_code <= FC_INVALID; fault_level <= lvl; state <= ST_IDLE;
            end
            default: begin
              walk_fault <= 1'b1; fault_code <= FC_RESERVED; fault_level <= lvl; state <= ST_IDLE;
            end
          endcase
        end
        ST_WR: state <= ST_WRW;
        ST_WRW: if (mem_ack) begin walk_done <= 1'b1; state <= ST_IDLE; end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: outcome pulses are exclusive
  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(walk_done && walk_fault));
  // R9: no memory traffic while a new request could be accepted
  assert_busy_mem_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
  // R9: walker reopens right after an outcome pulse
  assert_reopen_R9: assert property (@(posedge clk) disable iff (rst)
    (walk_done || walk_fault) |=> req_ready);
  // R6: every write-back carries the referenced bit
  assert_wb_ref_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[B_REF]);
  // R4: pointer-at-last-level fault is only reported at level 3
  assert_deep_ptr_R4: assert property (@(posedge clk) disable iff (rst)
    (walk_fault && fault_code == FC_DEEP_PTR) |-> fault_level == 2'd3);
  // R5: user access to codes 6 and 7 always faults
  assert_user_none_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDW && mem_ack && mem_rdata[1:0] == 2'd2 && user_q && mem_rdata[4:3] == 2'b11)
    |=> (walk_fault && fault_code == FC_PROT));
endmodule

// File: tb/test_tbl_walker.sv
`timescale 1ns/1ps
module test_tbl_walker;
  import ptw_pkg::*;

  typedef struct packed {
    logic [3:0]  ctx;
    logic [31:0] va;
    logic        wr, ex, us;
    logic [1:0]  lvl;
    logic [31:0] word;
    logic [2:0]  efc;
    logic [35:0] epa;
    logic        ec;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  32'h12345678, 1'b0, 1'b0, 1'b0, 2'd3, 32'h00ABCD8E, 3'd0, 36'h00ABCD678, 1'b1},
    '{4'd2,  32'h00041ABC, 1'b1, 1'b0, 1'b1, 2'd3, 32'h12345626, 3'd0, 36'h123456ABC, 1'b0},
    '{4'd3,  32'h00FFF123, 1'b0, 1'b0, 1'b1, 2'd3, 32'h000777A2, 3'd0, 36'h000777123, 1'b1},
    '{4'd4,  32'h0ABCDEF0, 1'b0, 1'b0, 1'b0, 2'd2, 32'hFEDCBAAE, 3'd0, 36'hFEDC8DEF0, 1'b1},
    '{4'd5,  32'h55667788, 1'b0, 1'b0, 1'b0, 2'd1, 32'h9ABCDEAE, 3'd0, 36'h9AB667788, 1'b1},
    '{4'd6,  32'hDEADBEEF, 1'b0, 1'b0, 1'b0, 2'd0, 32'h300000AE, 3'd0, 36'h3DEADBEEF, 1'b1},
    '{4'd7,  32'h01234567, 1'b0, 1'b0, 1'b0, 2'd2, 32'h00000000, 3'd1, 36'h0, 1'b0},
    '{4'd8,  32'h89ABCDEF, 1'b0, 1'b0, 1'b0, 2'd1, 32'h00000003, 3'd2, 36'h0, 1'b0},
    '{4'd9,  32'h00C0FFEE, 1'b0, 1'b0, 1'b0, 2'd3, 32'h000000C1, 3'd3, 36'h0, 1'b0},
    '{4'd10, 32'h00001000, 1'b0, 1'b0, 1'b1, 2'd3, 32'h0000101A, 3'd4, 36'h0, 1'b0},
    '{4'd11, 32'h00002000, 1'b1, 1'b0, 1'b0, 2'd3, 32'h000010A2, 3'd4, 36'h0, 1'b0},
    '{4'd12, 32'h00003456, 1'b0, 1'b1, 1'b1, 2'd3, 32'h000020B2, 3'd0, 36'h000020456, 1'b1},
    '{4'd13, 32'h00005FFF, 1'b1, 1'b0, 1'b0, 2'd3, 32'h00004016, 3'd0, 36'h000040FFF, 1'b0},
    '{4'd14, 32'h00006000, 1'b1, 1'b0, 1'b1, 2'd3, 32'h00004016, 3'd4, 36'h0, 1'b0},
    '{4'd15, 32'h7FFFFFFF, 1'b0, 1'b0, 1'b0, 2'd0, 32'h00000000, 3'd1, 36'h0, 1'b0},
    '{4'd0,  32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 2'd3, 32'hFFFFFF8A, 3'd0, 36'hFFFFFFFFF, 1'b1}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, req_valid, req_ready, req_write, req_exec, req_user;
  logic [31:0] req_vaddr;
  logic [3:0]  req_ctx;
  logic [35:6] ctb;
  logic mem_req, mem_we, mem_ack;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic walk_done, walk_fault, phys_cacheable;
  logic [2:0] fault_code;
  logic [1:0] fault_level;
  logic [35:0] phys_addr;

  tbl_walker i_tbl_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_ctx(req_ctx), .req_write(req_write), .req_exec(req_exec),
    .req_user(req_user), .ctx_table_base(ctb), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .walk_done(walk_done), .walk_fault(walk_fault), .fault_code(fault_code),
    .fault_level(fault_level), .phys_addr(phys_addr), .phys_cacheable(phys_cacheable));

  // memory model: ack two cycles after the strobe
  logic [31:0] mem [0:4095];
  logic        pend, m_we;
  logic [1:0]  cnt;
  logic [35:0] m_addr;
  logic [31:0] m_wd;
  always @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0; mem_ack <= 1'b0; cnt <= 2'd0; mem_rdata <= '0;
    end else begin
      mem_ack <= 1'b0;
      if (pend) begin
        if (cnt == 2'd1) begin
          mem_ack <= 1'b1;
          mem_rdata <= mem[m_addr[13:2]];
          if (m_we) mem[m_addr[13:2]] = m_wd;
          pend <= 1'b0;
        end else cnt <= cnt + 2'd1;
      end
      if (mem_req) begin
        pend <= 1'b1; cnt <= 2'd0; m_addr <= mem_addr; m_we <= mem_we; m_wd <= mem_wdata;
      end
    end
  end

  // request monitor
  int n_rd, n_wr;
  logic [35:0] first_rd, wr_addr;
  logic [31:0] wr_data;
  always @(posedge clk) begin
    if (!rst && mem_req) begin
      if (mem_we) begin n_wr = n_wr + 1; wr_addr = mem_addr; wr_data = mem_wdata; end
      else begin if (n_rd == 0) first_rd = mem_addr; n_rd = n_rd + 1; end
    end
  end

  int n_chk = 0, n_err = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input int vi);
    logic [35:0] cslot, rslot, sslot, pslot, eslot;
    logic [31:0] nw;
    bit exp_wb;
    string ptag, ftag;
    int t;
    cslot = {ctb, v.ctx, 2'b00};
    rslot = 36'h400 + {26'd0, v.va[31:24], 2'b00};
    sslot = 36'h800 + {28'd0, v.va[23:18], 2'b00};
    pslot = 36'hC00 + {28'd0, v.va[17:12], 2'b00};
    for (int k = 0; k < 4096; k++) mem[k] = 32'h0;
    mem[cslot[13:2]] = (v.lvl == 2'd0) ? v.word : 32'h41;
    if (v.lvl >= 2'd1) mem[rslot[13:2]] = (v.lvl == 2'd1) ? v.word : 32'h81;
    if (v.lvl >= 2'd2) mem[sslot[13:2]] = (v.lvl == 2'd2) ? v.word : 32'hC1;
    if (v.lvl == 2'd3) mem[pslot[13:2]] = v.word;
    case (v.lvl)
      2'd0: eslot = cslot; 2'd1: eslot = rslot; 2'd2: eslot = sslot; default: eslot = pslot;
    endcase
    nw = v.word | 32'h20 | ((v.wr && !v.ex) ? 32'h40 : 32'h0);
    exp_wb = (v.efc == 3'd0) && (nw != v.word);
    ptag = (v.lvl == 2'd3) ? "R7" : "R8";
    ftag = (v.efc == 3'd3) ? "R4" : ((v.efc == 3'd4) ? "R5" : "R1");
    n_rd = 0; n_wr = 0;
    @(negedge clk);
    req_vaddr = v.va; req_ctx = v.ctx; req_write = v.wr; req_exec = v.ex; req_user = v.us;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, $sformatf("R9 v%0d ready low after accept", vi), 64'(req_ready), 64'd0);
    t = 0;
    while (!(walk_done || walk_fault) && t < 400) begin @(negedge clk); t++; end
    chk(t < 400, $sformatf("R9 v%0d walk finished", vi), 64'(t), 64'd400);
    chk(first_rd == cslot, $sformatf("R2 v%0d context slot", vi), 64'(first_rd), 64'(cslot));
    chk(!req_ready, $sformatf("R9 v%0d ready low in pulse cycle", vi), 64'(req_ready), 64'd0);
    if (v.efc == 3'd0) begin
      chk(walk_done && !walk_fault, $sformatf("%s v%0d done", ptag, vi),
          64'({walk_done, walk_fault}), 64'h2);
      chk(phys_addr == v.epa, $sformatf("%s v%0d phys addr", ptag, vi), 64'(phys_addr), 64'(v.epa));
      chk(phys_cacheable == v.ec, $sformatf("R7 v%0d cacheable", vi), 64'(phys_cacheable), 64'(v.ec));
      chk(n_rd == int'(v.lvl) + 1, $sformatf("R3 v%0d read count", vi), 64'(n_rd), 64'(v.lvl + 1));
      chk(n_wr == (exp_wb ? 1 : 0), $sformatf("R6 v%0d write count", vi), 64'(n_wr), 64'(exp_wb));
      if (exp_wb) begin
        chk(wr_addr == eslot, $sformatf("R6 v%0d write addr", vi), 64'(wr_addr), 64'(eslot));
        chk(wr_data == nw, $sformatf("R6 v%0d write data", vi), 64'(wr_data), 64'(nw));
      end
    end else begin
      chk(walk_fault && !walk_done, $sformatf("%s v%0d fault", ftag, vi),
          64'({walk_done, walk_fault}), 64'h1);
      chk(fault_code == v.efc, $sformatf("%s v%0d fault code", ftag, vi), 64'(fault_code), 64'(v.efc));
      chk(fault_level == v.lvl, $sformatf("%s v%0d fault level", ftag, vi), 64'(fault_level), 64'(v.lvl));
      chk(n_wr == 0, $sformatf("R5 v%0d no write on fault", vi), 64'(n_wr), 64'd0);
    end
    @(negedge clk);
    chk(!walk_done && !walk_fault, $sformatf("R9 v%0d single pulse", vi),
        64'({walk_done, walk_fault}), 64'd0);
    chk(req_ready, $sformatf("R9 v%0d ready back", vi), 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_ctx = '0;
    req_write = 1'b0; req_exec = 1'b0; req_user = 1'b0; ctb = 30'h1;
    n_rd = 0; n_wr = 0; first_rd = '0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req && !walk_done && !walk_fault, "R10 outputs in reset",
        64'({req_ready, mem_req, walk_done, walk_fault}), 64'h8);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req, "R10 idle after reset", 64'({req_ready, mem_req}), 64'h2);
    chk(!walk_done && !walk_fault, "R10 no pulse after reset",
        64'({walk_done, walk_fault}), 64'd0);
    for (int i = 0; i < NV; i++) run(VECS[i], i);
    // corner: a different context table base moves only the first read
    ctb = 30'h2;
    run(VECS[0], 100);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule